// File: doc/BRIEF.md
# Code Flash Line Buffer with Sequential Prefetch

This block sits between a processor instruction-fetch port and a code flash array whose every read yields a 256-bit line, which is four 64-bit double-words. The most recently fetched line is held in a line buffer. After each fetch the block reads the next sequential line into a prefetch buffer. Each fetch request carries a double-word address and a burst length. The request is compared against both buffers. A match is served without waiting on the array, and the requested double-words then leave at one per cycle.

A second, independent path serves the data flash. It reads 64 bits at a time through its own one-entry read buffer and never touches the code buffers or the code array port. A single invalidate input drops every valid bit in both paths, for use after the flash contents have been changed. Three event counters report buffer hits, prefetch hits and misses on the code path.

Top module: `cfl_fetch_buf`

## Requirements
- R1: After reset no response is valid, all three counters read zero, and the code and data request ready outputs are high.
- R2: A code request whose line address (`creq_addr_i[AW-1:2]`) equals the line buffer's line is a buffer hit. It causes no array read, increments `hit_cnt_o`, and its first double-word is valid in the cycle after acceptance.
- R3: A burst length field n (0 to 3) yields n+1 double-words on consecutive cycles. The words come from the same line, starting at word w = `creq_addr_i[1:0]` and continuing as (w+i) mod 4. `crsp_last_o` is high only on the final one, and no response follows it.
- R4: A request that hits neither buffer is a miss. It increments `miss_cnt_o` and issues exactly one array read of its line, with word k of the line taken from `carr_rdata_i[64k+63:64k]`. It discards the prefetch buffer and forwards the requested words once the line returns.
- R5: After every miss or prefetch hit, the line (L+1) mod 2^(AW-2) is read from the array into the prefetch buffer, where L is the line just placed in the line buffer.
- R6: A request matching only the prefetch buffer is a prefetch hit. It increments `pf_hit_cnt_o`, causes no demand read, moves the prefetched line into the line buffer and serves from it.
- R7: At most one code array read is outstanding. A request that is not a buffer hit waits with `creq_ready_o` low while a read is in flight or pending.
- R8: A pulse on `inval_i` clears the valid bits of the line, prefetch and data buffers. A following request to a previously buffered line or data address is a miss.
- R9: A data request whose address equals the data buffer's address returns the buffered 64 bits in the next cycle without a data array read. Any other data request performs one data array read and returns its result.
- R10: Data-path traffic leaves the code buffers unchanged: no code array read, no counter change, and a code request that hit before still hits after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inval_i | input | 1 | Clear all buffer valid bits |
| creq_valid_i | input | 1 | Code fetch request valid |
| creq_ready_o | output | 1 | Code fetch request accepted when high with valid |
| creq_addr_i | input | AW | Code double-word address |
| creq_len_i | input | 2 | Burst length minus one |
| crsp_valid_o | output | 1 | Code response double-word valid |
| crsp_last_o | output | 1 | Final double-word of the burst |
| crsp_data_o | output | 64 | Code response double-word |
| carr_req_o | output | 1 | Code array read strobe |
| carr_line_o | output | AW-2 | Code array line address |
| carr_rvalid_i | input | 1 | Code array read data valid |
| carr_rdata_i | input | 256 | Code array line data |
| dreq_valid_i | input | 1 | Data flash request valid |
| dreq_ready_o | output | 1 | Data flash request accepted when high with valid |
| dreq_addr_i | input | DAW | Data flash double-word address |
| drsp_valid_o | output | 1 | Data response valid |
| drsp_data_o | output | 64 | Data response |
| darr_req_o | output | 1 | Data array read strobe |
| darr_addr_o | output | DAW | Data array address |
| darr_rvalid_i | input | 1 | Data array read data valid |
| darr_rdata_i | input | 64 | Data array read data |
| hit_cnt_o | output | CW | Buffer hit count |
| pf_hit_cnt_o | output | CW | Prefetch hit count |
| miss_cnt_o | output | CW | Miss count |

## Verification
The hardest states to reach are a prefetch hit on a line that wrapped from the top of the address space to line zero, and a request that arrives while a prefetch is still in flight, where buffer hits must still pass and anything else must stall. Directed cases start a miss on the highest line and then request line zero. A random phase issues requests back to back on a small window of neighbouring lines, so that requests repeatedly overlap running prefetches. A bench model of both buffers predicts every classification, the array read count and every double-word.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DEMAND, ST_SERVE} cfl_state_e;
endpackage

// File: rtl/cfl_evt_ctr.sv
module cfl_evt_ctr #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cfl_burst_srv.sv
module cfl_burst_srv #(
  parameter int WB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [WB-1:0] word_i,
  input  logic [WB-1:0] len_i,
  output logic          act_o,
  output logic          last_o,
  output logic [WB-1:0] idx_o
);
  logic [WB-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
      idx_o <= '0;
      rem_q <= '0;
    end else if (start_i) begin
      act_o <= 1'b1;
      idx_o <= word_i;
      rem_q <= len_i;
    end else if (act_o) begin
      if (rem_q == '0) act_o <= 1'b0;
      else begin
        idx_o <= idx_o + 1'b1;  // wraps within the line
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign last_o = act_o && (rem_q == '0);

  assert_beats_contig_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o && !last_o |=> act_o && idx_o == $past(idx_o) + 1'b1);
  assert_stop_after_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !act_o);
endmodule

// File: rtl/cfl_dflash_buf.sv
module cfl_dflash_buf #(
  parameter int DAW = 14,
  parameter int DW  = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           inval_i,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic [DAW-1:0] req_addr_i,
  output logic           rsp_valid_o,
  output logic [DW-1:0]  rsp_data_o,
  output logic           arr_req_o,
  output logic [DAW-1:0] arr_addr_o,
  input  logic           arr_rvalid_i,
  input  logic [DW-1:0]  arr_data_i
);
  logic           buf_valid, busy, stale;
  logic [DAW-1:0] buf_addr;
  logic [DW-1:0]  buf_data;
  logic           accept, hit;

  assign req_ready_o = !busy && !inval_i;
  assign accept      = req_valid_i && req_ready_o;
  assign hit         = buf_valid && (buf_addr == req_addr_i);
  assign arr_req_o   = accept && !hit;
  assign arr_addr_o  = req_addr_i;
  assign rsp_data_o  = buf_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_valid   <= 1'b0;
      buf_addr    <= '0;
      buf_data    <= '0;
      busy        <= 1'b0;
      stale       <= 1'b0;
      rsp_valid_o <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (accept && hit) rsp_valid_o <= 1'b1;
      if (arr_req_o) begin
        busy     <= 1'b1;
        stale    <= 1'b0;
        buf_addr <= req_addr_i;
      end
      if (arr_rvalid_i && busy) begin
        busy        <= 1'b0;
        buf_data    <= arr_data_i;
        buf_valid   <= !stale;
        rsp_valid_o <= 1'b1;
      end
      if (inval_i) begin
        buf_valid <= 1'b0;
        if (busy) stale <= 1'b1;
      end
    end
  end

  assert_dhit_next_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && hit |=> rsp_valid_o && $stable(buf_data));
  assert_dread_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !arr_req_o);
  assert_dinval_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !buf_valid);
endmodule

// File: rtl/cfl_fetch_buf.sv
module cfl_fetch_buf
  import cfl_pkg::*;
#(
  parameter int AW  = 20,
  parameter int DAW = 14,
  parameter int DW  = 64,
  parameter int WPL = 4,
  parameter int CW  = 16,
  localparam int WB     = $clog2(WPL),
  localparam int LAW    = AW - WB,
  localparam int LINE_W = DW * WPL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inval_i,
  input  logic              creq_valid_i,
  output logic              creq_ready_o,
  input  logic [AW-1:0]     creq_addr_i,
  input  logic [WB-1:0]     creq_len_i,
  output logic              crsp_valid_o,
  output logic              crsp_last_o,
  output logic [DW-1:0]     crsp_data_o,
  output logic              carr_req_o,
  output logic [LAW-1:0]    carr_line_o,
  input  logic              carr_rvalid_i,
  input  logic [LINE_W-1:0] carr_rdata_i,
  input  logic              dreq_valid_i,
  output logic              dreq_ready_o,
  input  logic [DAW-1:0]    dreq_addr_i,
  output logic              drsp_valid_o,
  output logic [DW-1:0]     drsp_data_o,
  output logic              darr_req_o,
  output logic [DAW-1:0]    darr_addr_o,
  input  logic              darr_rvalid_i,
  input  logic [DW-1:0]     darr_rdata_i,
  output logic [CW-1:0]     hit_cnt_o,
  output logic [CW-1:0]     pf_hit_cnt_o,
  output logic [CW-1:0]     miss_cnt_o
);
  cfl_state_e        state;
  logic              lb_valid, pf_valid, pf_want, arr_busy, arr_is_pf, stale;
  logic [LAW-1:0]    lb_line, pf_line, pf_target, dem_line;
  logic [LINE_W-1:0] lb_data, pf_data;
  logic [WB-1:0]     req_word, req_len;

  logic [LAW-1:0] req_line;
  logic           lb_hit, pf_hit, accept, dem_issue, pf_issue, dem_ret;
  logic           srv_start, srv_act, srv_last;
  logic [WB-1:0]  srv_idx, start_word, start_len;

  assign req_line     = creq_addr_i[AW-1:WB];
  assign lb_hit       = lb_valid && (lb_line == req_line);
  assign pf_hit       = pf_valid && (pf_line == req_line);
  assign creq_ready_o = (state == ST_IDLE) && !inval_i && (lb_hit || (!arr_busy && !pf_want));
  assign accept       = creq_valid_i && creq_ready_o;
  assign dem_issue    = accept && !lb_hit && !pf_hit;
  assign pf_issue     = pf_want && !arr_busy && (state != ST_DEMAND) && !dem_issue;
  assign carr_req_o   = dem_issue || pf_issue;
  assign carr_line_o  = dem_issue ? req_line : pf_target;
  assign dem_ret      = carr_rvalid_i && arr_busy && !arr_is_pf;

  assign srv_start  = (accept && (lb_hit || pf_hit)) || dem_ret;
  assign start_word = (state == ST_IDLE) ? creq_addr_i[WB-1:0] : req_word;
  assign start_len  = (state == ST_IDLE) ? creq_len_i : req_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      lb_valid  <= 1'b0;
      pf_valid  <= 1'b0;
      pf_want   <= 1'b0;
      arr_busy  <= 1'b0;
      arr_is_pf <= 1'b0;
      stale     <= 1'b0;
      lb_line   <= '0;
      pf_line   <= '0;
      pf_target <= '0;
      dem_line  <= '0;
      lb_data   <= '0;
      pf_data   <= '0;
      req_word  <= '0;
      req_len   <= '0;
    end else begin
      if (accept) begin
        req_word <= creq_addr_i[WB-1:0];
        req_len  <= creq_len_i;
        if (lb_hit) begin
          state <= ST_SERVE;
        end else if (pf_hit) begin
          state     <= ST_SERVE;
          lb_line   <= pf_line;
          lb_data   <= pf_data;
          lb_valid  <= 1'b1;
          pf_valid  <= 1'b0;
          pf_want   <= 1'b1;
          pf_target <= pf_line + 1'b1;
        end else begin
          state    <= ST_DEMAND;
          pf_valid <= 1'b0;  // outstanding prefetch line dropped
          dem_line <= req_line;
        end
      end
      if (carr_req_o) begin
        arr_busy  <= 1'b1;
        arr_is_pf <= pf_issue;
        stale     <= 1'b0;
        if (pf_issue) pf_want <= 1'b0;
      end
      if (carr_rvalid_i && arr_busy) begin
        arr_busy <= 1'b0;
        if (arr_is_pf) begin
          if (!stale) begin
            pf_data  <= carr_rdata_i;
            pf_line  <= pf_target;
            pf_valid <= 1'b1;
          end
        end else begin
          state     <= ST_SERVE;
          lb_data   <= carr_rdata_i;
          lb_line   <= dem_line;
          lb_valid  <= !stale;
          pf_want   <= !stale;
          pf_target <= dem_line + 1'b1;
        end
      end
      if (state == ST_SERVE && srv_last) state <= ST_IDLE;
      if (inval_i) begin
        lb_valid <= 1'b0;
        pf_valid <= 1'b0;
        pf_want  <= 1'b0;
        if (arr_busy) stale <= 1'b1;
      end
    end
  end

  cfl_burst_srv #(.WB(WB)) u_srv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(srv_start),
    .word_i (start_word),
    .len_i  (start_len),
    .act_o  (srv_act),
    .last_o (srv_last),
    .idx_o  (srv_idx)
  );

  assign crsp_valid_o = srv_act;
  assign crsp_last_o  = srv_last;
  assign crsp_data_o  = lb_data[srv_idx*DW +: DW];

  cfl_evt_ctr #(.CW(CW)) u_hit_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(accept && lb_hit), .cnt_o(hit_cnt_o));
  cfl_evt_ctr #(.CW(CW)) u_pf_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(accept && !lb_hit && pf_hit), .cnt_o(pf_hit_cnt_o));
  cfl_evt_ctr #(.CW(CW)) u_miss_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(dem_issue), .cnt_o(miss_cnt_o));

  cfl_dflash_buf #(.DAW(DAW), .DW(DW)) u_dbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inval_i     (inval_i),
    .req_valid_i (dreq_valid_i),
    .req_ready_o (dreq_ready_o),
    .req_addr_i  (dreq_addr_i),
    .rsp_valid_o (drsp_valid_o),
    .rsp_data_o  (drsp_data_o),
    .arr_req_o   (darr_req_o),
    .arr_addr_o  (darr_addr_o),
    .arr_rvalid_i(darr_rvalid_i),
    .arr_data_i  (darr_rdata_i)
  );

  assert_hit_first_beat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && lb_hit |=> crsp_valid_o && hit_cnt_o == $past(hit_cnt_o) + 1'b1);
  assert_miss_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dem_issue |=> state == ST_DEMAND && arr_busy && !pf_valid);
  assert_pf_after_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dem_ret && !stale && !inval_i |=> pf_want && pf_target == $past(dem_line) + 1'b1);
  assert_pf_moves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !lb_hit && pf_hit |=> lb_valid && !pf_valid && !arr_busy && state == ST_SERVE);
  assert_one_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_busy |-> !carr_req_o);
  assert_inval_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !lb_valid && !pf_valid && !pf_want);
  assert_dpath_isolated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    darr_req_o && !creq_valid_i && !pf_want |-> !carr_req_o);
endmodule

// File: tb/cfl_fetch_buf_tb_top.sv
module cfl_fetch_buf_tb_top;
  localparam int AW = 20, DAW = 14, DW = 64, CW = 16;
  localparam int LAW = AW - 2;
  localparam int LAT = 3, DLAT = 2;

  logic clk = 1'b0, rst_n = 1'b0, inval = 1'b0;
  logic creq_valid = 1'b0, creq_ready;
  logic [AW-1:0] creq_addr = '0;
  logic [1:0] creq_len = '0;
  logic crsp_valid, crsp_last;
  logic [DW-1:0] crsp_data;
  logic carr_req, carr_rvalid = 1'b0;
  logic [LAW-1:0] carr_line;
  logic [4*DW-1:0] carr_rdata = '0;
  logic dreq_valid = 1'b0, dreq_ready;
  logic [DAW-1:0] dreq_addr = '0, darr_addr;
  logic drsp_valid, darr_req, darr_rvalid = 1'b0;
  logic [DW-1:0] drsp_data, darr_rdata = '0;
  logic [CW-1:0] hit_cnt, pf_cnt, miss_cnt;

  always #10 clk = ~clk;  // 50 MHz

  cfl_fetch_buf #(.AW(AW), .DAW(DAW), .DW(DW), .WPL(4), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .inval_i(inval),
    .creq_valid_i(creq_valid), .creq_ready_o(creq_ready), .creq_addr_i(creq_addr),
    .creq_len_i(creq_len), .crsp_valid_o(crsp_valid), .crsp_last_o(crsp_last),
    .crsp_data_o(crsp_data), .carr_req_o(carr_req), .carr_line_o(carr_line),
    .carr_rvalid_i(carr_rvalid), .carr_rdata_i(carr_rdata),
    .dreq_valid_i(dreq_valid), .dreq_ready_o(dreq_ready), .dreq_addr_i(dreq_addr),
    .drsp_valid_o(drsp_valid), .drsp_data_o(drsp_data), .darr_req_o(darr_req),
    .darr_addr_o(darr_addr), .darr_rvalid_i(darr_rvalid), .darr_rdata_i(darr_rdata),
    .hit_cnt_o(hit_cnt), .pf_hit_cnt_o(pf_cnt), .miss_cnt_o(miss_cnt));

  int errors = 0, checks = 0;
  int arr_reads = 0, darr_reads = 0;
  int exp_arr = 0, exp_darr = 0;
  int exp_hit = 0, exp_pf = 0, exp_miss = 0;
  bit m_lbv = 0, m_pfv = 0, m_dv = 0;
  logic [LAW-1:0] m_lb = '0, m_pf = '0;
  logic [DAW-1:0] m_da = '0;

  function automatic logic [DW-1:0] cword(logic [LAW-1:0] line, int w);
    return 64'hC0DE_0000_0000_0000 ^ (64'(line) << 8) ^ 64'(w);
  endfunction
  function automatic logic [DW-1:0] dword(logic [DAW-1:0] a);
    return 64'hDA7A_5000_0000_0000 ^ (64'(a) << 4);
  endfunction

  // code array model, fixed latency
  int pend = 0;
  logic [LAW-1:0] pend_line;
  always @(posedge clk) begin
    carr_rvalid <= 1'b0;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        carr_rvalid <= 1'b1;
        for (int k = 0; k < 4; k++) carr_rdata[k*DW +: DW] <= cword(pend_line, k);
      end
    end
    if (carr_req) begin
      pend <= LAT;
      pend_line <= carr_line;
      arr_reads <= arr_reads + 1;
    end
  end

  int dpend = 0;
  logic [DAW-1:0] dpend_addr;
  always @(posedge clk) begin
    darr_rvalid <= 1'b0;
    if (dpend > 0) begin
      dpend <= dpend - 1;
      if (dpend == 1) begin
        darr_rvalid <= 1'b1;
        darr_rdata <= dword(dpend_addr);
      end
    end
    if (darr_req) begin
      dpend <= DLAT;
      dpend_addr <= darr_addr;
      darr_reads <= darr_reads + 1;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_cnt(string req);
    chk(req, 64'(hit_cnt), 64'(exp_hit));
    chk(req, 64'(pf_cnt), 64'(exp_pf));
    chk(req, 64'(miss_cnt), 64'(exp_miss));
  endtask

  // kind: 0 buffer hit, 1 prefetch hit, 2 miss
  task automatic code_req(logic [AW-1:0] a, logic [1:0] len, bit settle, string req);
    logic [LAW-1:0] line = a[AW-1:2];
    int kind, n;
    if (m_lbv && m_lb == line) kind = 0;
    else if (m_pfv && m_pf == line) kind = 1;
    else kind = 2;
    @(negedge clk);
    creq_valid = 1'b1; creq_addr = a; creq_len = len;
    #1;
    while (!creq_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    creq_valid = 1'b0;
    case (kind)
      0: exp_hit++;
      1: begin exp_pf++; exp_arr += 1; m_lb = m_pf; m_lbv = 1; m_pf = line + 1'b1; m_pfv = 1; end
      default: begin exp_miss++; exp_arr += 2; m_lb = line; m_lbv = 1; m_pf = line + 1'b1; m_pfv = 1; end
    endcase
    n = 0;
    while (!crsp_valid && n < 20) begin @(negedge clk); n++; end
    if (kind == 0) chk({req, " R2 first beat delay"}, 64'(n), 64'd0);
    for (int i = 0; i <= int'(len); i++) begin
      if (i > 0) @(negedge clk);
      chk({req, " R3 beat valid"}, 64'(crsp_valid), 64'd1);
      chk({req, " R4 beat data"}, crsp_data, cword(line, (int'(a[1:0]) + i) % 4));
      chk({req, " R3 last flag"}, 64'(crsp_last), 64'(i == int'(len)));
    end
    @(negedge clk);
    chk({req, " R3 no extra beat"}, 64'(crsp_valid), 64'd0);
    chk_cnt({req, " R6 counters"});
    if (settle) begin
      repeat (8) @(negedge clk);
      chk({req, " R5 array reads"}, 64'(arr_reads), 64'(exp_arr));
    end
  endtask

  task automatic data_req(logic [DAW-1:0] a, string req);
    bit hit = m_dv && m_da == a;
    int n;
    @(negedge clk);
    dreq_valid = 1'b1; dreq_addr = a;
    #1;
    while (!dreq_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    dreq_valid = 1'b0;
    n = 0;
    while (!drsp_valid && n < 20) begin @(negedge clk); n++; end
    if (hit) chk({req, " R9 hit delay"}, 64'(n), 64'd0);
    else exp_darr++;
    m_dv = 1; m_da = a;
    chk({req, " R9 data"}, drsp_data, dword(a));
    repeat (4) @(negedge clk);
    chk({req, " R9 data array reads"}, 64'(darr_reads), 64'(exp_darr));
    chk({req, " R10 code array untouched"}, 64'(arr_reads), 64'(exp_arr));
    chk_cnt({req, " R10 counters unchanged"});
  endtask

  task automatic do_inval();
    @(negedge clk); inval = 1'b1;
    @(negedge clk); inval = 1'b0;
    m_lbv = 0; m_pfv = 0; m_dv = 0;
  endtask

  initial begin
    int seed;
    logic [LAW-1:0] base;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    chk("R1 rsp idle", 64'(crsp_valid), 64'd0);
    chk("R1 drsp idle", 64'(drsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 code ready", 64'(creq_ready), 64'd1);
    chk("R1 data ready", 64'(dreq_ready), 64'd1);
    chk_cnt("R1 counters zero");

    code_req(20'h01238, 2'd0, 1, "R4 miss");
    code_req(20'h0123A, 2'd3, 1, "R3 wrap burst");
    code_req(20'h01239, 2'd1, 1, "R2 hit");
    code_req(20'h0123C, 2'd3, 1, "R6 prefetch hit");
    code_req(20'h01240, 2'd2, 1, "R5 chained prefetch");
    code_req(20'h00100, 2'd0, 1, "R4 miss drops prefetch");
    code_req(20'h01244, 2'd0, 1, "R4 old prefetch gone");
    data_req(14'h0155, "R9 data miss");
    data_req(14'h0155, "R9 data hit");
    data_req(14'h0AAA, "R9 data other");
    code_req(20'h01246, 2'd1, 1, "R10 code hit after data");
    do_inval();
    code_req(20'h01245, 2'd0, 1, "R8 miss after invalidate");
    data_req(14'h0AAA, "R8 data miss after invalidate");
    code_req(20'hFFFFE, 2'd3, 1, "R5 top line miss");
    code_req(20'h00001, 2'd3, 1, "R5 wrapped prefetch hit");

    base = 18'h00400;
    for (int i = 0; i < 150; i++) begin
      logic [AW-1:0] a;
      a = {base + LAW'($urandom_range(0, 5)), 2'($urandom_range(0, 3))};
      if ($urandom_range(0, 9) == 0) base = base + LAW'($urandom_range(1, 3));
      if ($urandom_range(0, 19) == 0) data_req(DAW'($urandom_range(0, 7)), "R10 random data");
      code_req(a, 2'($urandom_range(0, 3)), $urandom_range(0, 3) == 0, "R7 random");
    end
    repeat (10) @(negedge clk);
    chk("R7 final array reads", 64'(arr_reads), 64'(exp_arr));
    chk_cnt("R6 final counters");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule